// File: doc/BRIEF.md
# Descriptor Ring Queue Manager

This block keeps the books for a circular queue of fixed-size command descriptors that a host and a processing engine share in memory. The host fills descriptor slots itself, then tells the block how many new slots are ready by writing a count. The block hands these slots one at a time to the engine as fetch requests, each carrying the slot index and its memory address. The engine reports each finished descriptor with a single-cycle pulse. The host later hands completed slots back by writing a release count.

The block holds four ring positions: the host write position, the engine fetch position, the next completed slot the host has to handle, and the queue size. It also keeps the number of slots posted but not yet fetched, fetched but not yet finished, and finished but not yet released. A host register port sets the queue size, the base address and the descriptor size, and runs or halts fetching. Two status words report the completed count and completed-slot position, and the host write position with a sticky overflow flag. Moving the descriptors, their contents and any interrupt signalling belong to other blocks.

Top module: `rq_ring_mgr`

## Requirements
- R1: After reset the completed count, all ring positions, the overflow flag and `fetch_req` are zero, the stop bit reads 1, the descriptor-size register reads 1 and the queue size reads 16.
- R2: A write to the size register (offset 0x008) sets the queue size clamped to the range 1 to the mode maximum: 16384 entries with 32-byte descriptors and 4096 entries with 128-byte descriptors. It also clears every position, every count and the overflow flag.
- R3: The descriptor-size register (offset 0x100) accepts 1 (32-byte slots) or 7 (128-byte slots). Any other written value leaves it unchanged. It reads back the held code.
- R4: A write of N to the add register (offset 0x808) accepts min(N, free slots), where free slots are the queue size minus posted, in-flight and completed slots. The host write position advances by the accepted amount modulo the queue size. If N exceeds the free slots, a sticky overflow flag is set. The allocation status word (offset 0x04C) reports the write position in bits [31:16] and the overflow flag in bit 0.
- R5: `fetch_req` is high exactly when at least one posted slot is unfetched and the engine is not stopped. `fetch_idx` is the fetch position, and each `fetch_ack` pulse while `fetch_req` is high advances it by one modulo the queue size. An acknowledge while `fetch_req` is low has no effect.
- R6: `fetch_addr` equals the 48-bit base address plus `fetch_idx` times the descriptor size (32 or 128 bytes). The base is formed from offset 0x000 (bits 31:0) and bits [15:0] of offset 0x004 (address bits 47:32).
- R7: A `done_pulse` increments the completed count when at least one slot is in flight. When no slot is in flight, the pulse is ignored.
- R8: A write of N to the release register (offset 0x804) removes min(N, completed count) slots. The completed-slot position advances by that amount modulo the queue size.
- R9: The done status word (offset 0x00C) reports the completed, unreleased count in bits [14:0] and the completed-slot position in bits [29:16].
- R10: Bit 0 of the stop register (offset 0x800) halts fetching when 1 and enables it when 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wen | input | 1 | Register write strobe |
| host_addr | input | 12 | Register byte offset for read and write |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| fetch_req | output | 1 | A posted descriptor is waiting for the engine |
| fetch_idx | output | 14 | Ring index of the descriptor to fetch |
| fetch_addr | output | 48 | Memory address of the descriptor to fetch |
| fetch_ack | input | 1 | One-cycle pulse: engine took the requested descriptor |
| done_pulse | input | 1 | One-cycle pulse: engine finished one descriptor |

## Verification
The bound checker checks these invariants on every cycle. Posted, in-flight and completed slots never exceed the queue size. Every ring position stays below the size, and the size stays inside its legal range. A fetch request never appears while stopped or with nothing posted. The fetch index moves only on an acknowledge. The overflow flag, once set, holds until the queue is reconfigured. A stray done pulse never changes the completed count. Only the bench's scenarios show the values themselves: clipping of oversized add and release counts, wraparound of each position at the programmed size, address scaling under each descriptor size, clamping of the size register, and the exact packing of both status words.

// File: rtl/rq_pkg.sv
package rq_pkg;

    // Register byte offsets; host software decodes these.
    localparam logic [11:0] RA_BASE_LO = 12'h000;
    localparam logic [11:0] RA_BASE_HI = 12'h004;
    localparam logic [11:0] RA_SIZE    = 12'h008;
    localparam logic [11:0] RA_DONE_ST = 12'h00C;
    localparam logic [11:0] RA_ALLOC   = 12'h04C;
    localparam logic [11:0] RA_DSZ     = 12'h100;
    localparam logic [11:0] RA_STOP    = 12'h800;
    localparam logic [11:0] RA_RELEASE = 12'h804;
    localparam logic [11:0] RA_ADD     = 12'h808;

    // Descriptor size selector codes.
    typedef enum logic [2:0] {
        DSZ_32B  = 3'd1,
        DSZ_128B = 3'd7
    } dsz_e;

    // Host command decoded from a register write.
    typedef struct packed {
        logic        add;
        logic        rel;
        logic        clr;
        logic [31:0] n;
    } qcmd_t;

    // Advance a ring position p by n (n <= sz) with wrap at sz.
    function automatic logic [31:0] ring_adv(input logic [31:0] p,
                                             input logic [31:0] n,
                                             input logic [31:0] sz);
        logic [32:0] s;
        s = {1'b0, p} + {1'b0, n};
        if (s >= {1'b0, sz}) s = s - {1'b0, sz};
        return s[31:0];
    endfunction

    function automatic logic [31:0] min32(input logic [31:0] a,
                                          input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rq_regfile.sv
module rq_regfile
    import rq_pkg::*;
#(
    parameter int CNT_W      = 15,
    parameter int AW         = 48,
    parameter int DEF_SIZE   = 16,
    parameter int SMALL_LOG2 = 14,
    parameter int LARGE_LOG2 = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wen,
    input  logic [11:0]      host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic [CNT_W-1:0] st_done_cnt,
    input  logic [CNT_W-1:0] st_done_ptr,
    input  logic [CNT_W-1:0] st_wr_ptr,
    input  logic             st_ovf,
    output logic [AW-1:0]    q_base,
    output logic [CNT_W-1:0] q_size,
    output logic             mode_large,
    output logic             stopped,
    output qcmd_t            cmd
);
    localparam int HI_W      = AW - 32;
    localparam int MAX_SMALL = 1 << SMALL_LOG2;
    localparam int MAX_LARGE = 1 << LARGE_LOG2;

    logic [31:0]   base_lo;
    logic [HI_W-1:0] base_hi;
    logic [31:0]   size_lim;
    logic [31:0]   size_new;

    assign q_base = {base_hi, base_lo};

    always_comb begin
        size_lim = mode_large ? 32'(MAX_LARGE) : 32'(MAX_SMALL);
        if (host_wdata == 32'd0)
            size_new = 32'd1;
        else
            size_new = min32(host_wdata, size_lim);
    end

    always_comb begin
        cmd.add = host_wen && (host_addr == RA_ADD);
        cmd.rel = host_wen && (host_addr == RA_RELEASE);
        cmd.clr = host_wen && (host_addr == RA_SIZE);
        cmd.n   = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo    <= '0;
            base_hi    <= '0;
            q_size     <= CNT_W'(DEF_SIZE);
            mode_large <= 1'b0;
            stopped    <= 1'b1;
        end else if (host_wen) begin
            case (host_addr)
                RA_BASE_LO: base_lo <= host_wdata;
                RA_BASE_HI: base_hi <= host_wdata[HI_W-1:0];
                RA_SIZE:    q_size  <= size_new[CNT_W-1:0];
                RA_DSZ: begin
                    if (host_wdata == 32'(DSZ_32B))
                        mode_large <= 1'b0;
                    else if (host_wdata == 32'(DSZ_128B))
                        mode_large <= 1'b1;
                end
                RA_STOP:    stopped <= host_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (host_addr)
            RA_BASE_LO: host_rdata = base_lo;
            RA_BASE_HI: host_rdata = 32'(base_hi);
            RA_SIZE:    host_rdata = 32'(q_size);
            RA_DONE_ST: host_rdata = (32'(st_done_ptr) << 16) | 32'(st_done_cnt);
            RA_ALLOC:   host_rdata = (32'(st_wr_ptr) << 16) | 32'(st_ovf);
            RA_DSZ:     host_rdata = mode_large ? 32'(DSZ_128B) : 32'(DSZ_32B);
            RA_STOP:    host_rdata = 32'(stopped);
            default:    host_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/rq_ptr_engine.sv
module rq_ptr_engine
    import rq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  qcmd_t            cmd,
    input  logic [CNT_W-1:0] q_size,
    input  logic             stopped,
    input  logic             fetch_ack,
    input  logic             done_pulse,
    output logic             fetch_req,
    output logic [CNT_W-1:0] avail_cnt,
    output logic [CNT_W-1:0] fly_cnt,
    output logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] fch_ptr,
    output logic [CNT_W-1:0] dn_ptr,
    output logic             ovf
);
    logic [31:0] used;
    logic [31:0] free_slots;
    logic [31:0] add_n;
    logic [31:0] rel_n;
    logic        fetch_go;
    logic        done_go;
    logic [31:0] avail_n;
    logic [31:0] fly_n;
    logic [31:0] done_n;

    assign fetch_req = (avail_cnt != '0) && !stopped;

    always_comb begin
        used       = 32'(avail_cnt) + 32'(fly_cnt) + 32'(done_cnt);
        free_slots = 32'(q_size) - used;
        add_n      = cmd.add ? min32(cmd.n, free_slots) : 32'd0;
        rel_n      = cmd.rel ? min32(cmd.n, 32'(done_cnt)) : 32'd0;
        fetch_go   = fetch_ack && fetch_req;
        done_go    = done_pulse && (fly_cnt != '0);
        avail_n    = 32'(avail_cnt) + add_n - 32'(fetch_go);
        fly_n      = 32'(fly_cnt) + 32'(fetch_go) - 32'(done_go);
        done_n     = 32'(done_cnt) + 32'(done_go) - rel_n;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            avail_cnt <= '0;
            fly_cnt   <= '0;
            done_cnt  <= '0;
            wr_ptr    <= '0;
            fch_ptr   <= '0;
            dn_ptr    <= '0;
            ovf       <= 1'b0;
        end else begin
            avail_cnt <= avail_n[CNT_W-1:0];
            fly_cnt   <= fly_n[CNT_W-1:0];
            done_cnt  <= done_n[CNT_W-1:0];
            if (cmd.add) begin
                wr_ptr <= CNT_W'(ring_adv(32'(wr_ptr), add_n, 32'(q_size)));
                if (cmd.n > free_slots) ovf <= 1'b1;
            end
            if (fetch_go)
                fch_ptr <= CNT_W'(ring_adv(32'(fch_ptr), 32'd1, 32'(q_size)));
            if (cmd.rel)
                dn_ptr <= CNT_W'(ring_adv(32'(dn_ptr), rel_n, 32'(q_size)));
        end
    end

endmodule

// File: rtl/rq_fetch_addr.sv
module rq_fetch_addr #(
    parameter int CNT_W     = 15,
    parameter int AW        = 48,
    parameter int SMALL_SH  = 5,
    parameter int LARGE_SH  = 7
) (
    input  logic [AW-1:0]    q_base,
    input  logic [CNT_W-1:0] idx,
    input  logic             mode_large,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] off_small;
    logic [AW-1:0] off_large;

    assign off_small = AW'(idx) << SMALL_SH;
    assign off_large = AW'(idx) << LARGE_SH;
    assign addr      = q_base + (mode_large ? off_large : off_small);

endmodule

// File: rtl/rq_ring_mgr.sv
module rq_ring_mgr
    import rq_pkg::*;
#(
    parameter int SMALL_LOG2 = 14,
    parameter int LARGE_LOG2 = 12,
    parameter int AW         = 48,
    parameter int DEF_SIZE   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wen,
    input  logic [11:0]           host_addr,
    input  logic [31:0]           host_wdata,
    output logic [31:0]           host_rdata,
    output logic                  fetch_req,
    output logic [SMALL_LOG2-1:0] fetch_idx,
    output logic [AW-1:0]         fetch_addr,
    input  logic                  fetch_ack,
    input  logic                  done_pulse
);
    localparam int CNT_W = SMALL_LOG2 + 1;

    qcmd_t            cmd;
    logic [AW-1:0]    q_base;
    logic [CNT_W-1:0] q_size;
    logic             mode_large;
    logic             stopped;
    logic             cfg_clr;
    logic [CNT_W-1:0] avail_cnt;
    logic [CNT_W-1:0] fly_cnt;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] wr_ptr;
    logic [CNT_W-1:0] fch_ptr;
    logic [CNT_W-1:0] dn_ptr;
    logic             ovf;

    assign cfg_clr   = cmd.clr;
    assign fetch_idx = fch_ptr[SMALL_LOG2-1:0];

    rq_regfile #(
        .CNT_W(CNT_W), .AW(AW), .DEF_SIZE(DEF_SIZE),
        .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)
    ) u_regs (
        .clk(clk), .rst(rst),
        .host_wen(host_wen), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .st_done_cnt(done_cnt), .st_done_ptr(dn_ptr),
        .st_wr_ptr(wr_ptr), .st_ovf(ovf),
        .q_base(q_base), .q_size(q_size), .mode_large(mode_large),
        .stopped(stopped), .cmd(cmd)
    );

    rq_ptr_engine #(.CNT_W(CNT_W)) u_ptrs (
        .clk(clk), .rst(rst), .cmd(cmd), .q_size(q_size),
        .stopped(stopped), .fetch_ack(fetch_ack), .done_pulse(done_pulse),
        .fetch_req(fetch_req), .avail_cnt(avail_cnt), .fly_cnt(fly_cnt),
        .done_cnt(done_cnt), .wr_ptr(wr_ptr), .fch_ptr(fch_ptr),
        .dn_ptr(dn_ptr), .ovf(ovf)
    );

    rq_fetch_addr #(.CNT_W(CNT_W), .AW(AW)) u_addr (
        .q_base(q_base), .idx(fch_ptr), .mode_large(mode_large),
        .addr(fetch_addr)
    );

endmodule

// File: rtl/rq_ring_mgr_chk.sv
module rq_ring_mgr_chk #(
    parameter int CNT_W      = 15,
    parameter int SMALL_LOG2 = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wen,
    input logic             fetch_req,
    input logic             fetch_ack,
    input logic             done_pulse,
    input logic [SMALL_LOG2-1:0] fetch_idx,
    input logic             stopped,
    input logic             cfg_clr,
    input logic             ovf,
    input logic [CNT_W-1:0] q_size,
    input logic [CNT_W-1:0] avail_cnt,
    input logic [CNT_W-1:0] fly_cnt,
    input logic [CNT_W-1:0] done_cnt,
    input logic [CNT_W-1:0] wr_ptr,
    input logic [CNT_W-1:0] dn_ptr
);
    // R4
    outstanding_fits_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(avail_cnt) + 32'(fly_cnt) + 32'(done_cnt)) <= 32'(q_size));

    // R5
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (!stopped && avail_cnt != '0));

    // R5
    idx_moves_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_ack && !cfg_clr) |=> $stable(fetch_idx));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !cfg_clr) |=> ovf);

    // R2
    size_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (q_size != '0) && (32'(q_size) <= (32'd1 << SMALL_LOG2)));

    // R8
    pos_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_ptr < q_size) && (wr_ptr < q_size));

    // R7
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && fly_cnt == '0 && !host_wen) |=> (done_cnt == $past(done_cnt)));

endmodule

bind rq_ring_mgr rq_ring_mgr_chk #(.CNT_W(CNT_W), .SMALL_LOG2(SMALL_LOG2)) u_chk (
    .clk(clk), .rst(rst), .host_wen(host_wen), .fetch_req(fetch_req),
    .fetch_ack(fetch_ack), .done_pulse(done_pulse), .fetch_idx(fetch_idx),
    .stopped(stopped), .cfg_clr(cfg_clr), .ovf(ovf), .q_size(q_size),
    .avail_cnt(avail_cnt), .fly_cnt(fly_cnt), .done_cnt(done_cnt),
    .wr_ptr(wr_ptr), .dn_ptr(dn_ptr)
);

// File: tb/tb_rq_ring_mgr.sv
module tb_rq_ring_mgr;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_wen;
    logic [11:0] host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        fetch_req;
    logic [13:0] fetch_idx;
    logic [47:0] fetch_addr;
    logic        fetch_ack;
    logic        done_pulse;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] BASE = 48'h1_0000_1000;

    always #4 clk = ~clk;

    rq_ring_mgr dut (
        .clk(clk), .rst(rst), .host_wen(host_wen), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .done_pulse(done_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wen = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic ack(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fetch_ack = 1'b1;
            @(negedge clk); fetch_ack = 1'b0;
        end
    endtask

    task automatic done(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); done_pulse = 1'b1;
            @(negedge clk); done_pulse = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h00C, v); chk("R1 done status", 64'(v), 64'h0);
        rd(12'h04C, v); chk("R1 alloc status", 64'(v), 64'h0);
        rd(12'h800, v); chk("R1 stop", 64'(v), 64'h1);
        rd(12'h100, v); chk("R1 dsz", 64'(v), 64'h1);
        rd(12'h008, v); chk("R1 size", 64'(v), 64'd16);
        chk("R1 fetch_req", 64'(fetch_req), 64'h0);
    endtask

    task automatic t_post_fetch;
        logic [31:0] v;
        wr(12'h008, 8);
        wr(12'h000, 32'h0000_1000);
        wr(12'h004, 32'h0000_0001);
        wr(12'h808, 3);
        chk("R10 stopped blocks req", 64'(fetch_req), 64'h0);
        wr(12'h800, 0);
        chk("R5 req after add", 64'(fetch_req), 64'h1);
        chk("R5 idx start", 64'(fetch_idx), 64'h0);
        chk("R6 addr idx0", 64'(fetch_addr), 64'(BASE));
        rd(12'h04C, v); chk("R4 wr pos 3", 64'(v), 64'h0003_0000);
        ack(1);
        chk("R5 idx after ack", 64'(fetch_idx), 64'h1);
        chk("R6 addr idx1 small", 64'(fetch_addr), 64'(BASE + 48'h20));
        ack(2);
        chk("R5 req drained", 64'(fetch_req), 64'h0);
        chk("R5 idx 3", 64'(fetch_idx), 64'h3);
        ack(1);
        chk("R5 stray ack ignored", 64'(fetch_idx), 64'h3);
    endtask

    task automatic t_done_release;
        logic [31:0] v;
        done(2);
        rd(12'h00C, v); chk("R9 done 2", 64'(v), 64'h0000_0002);
        wr(12'h804, 1);
        rd(12'h00C, v); chk("R8 release 1", 64'(v), 64'h0001_0001);
        wr(12'h804, 5);
        rd(12'h00C, v); chk("R8 release saturates", 64'(v), 64'h0002_0000);
        done(1);
        rd(12'h00C, v); chk("R7 third done", 64'(v), 64'h0002_0001);
        done(1);
        rd(12'h00C, v); chk("R7 done with none in flight", 64'(v), 64'h0002_0001);
        wr(12'h804, 1);
        rd(12'h00C, v); chk("R8 release last", 64'(v), 64'h0003_0000);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(12'h808, 6);
        rd(12'h04C, v); chk("R4 wrap wr pos", 64'(v), 64'h0001_0000);
        wr(12'h808, 5);
        rd(12'h04C, v); chk("R4 clipped add sets flag", 64'(v), 64'h0003_0001);
        wr(12'h808, 1);
        rd(12'h04C, v); chk("R4 full ring add", 64'(v), 64'h0003_0001);
    endtask

    task automatic t_stop;
        chk("R10 running req", 64'(fetch_req), 64'h1);
        wr(12'h800, 1);
        chk("R10 halted req", 64'(fetch_req), 64'h0);
        ack(1);
        chk("R10 ack while halted", 64'(fetch_idx), 64'h3);
        wr(12'h800, 0);
        chk("R10 resumed req", 64'(fetch_req), 64'h1);
    endtask

    task automatic t_addr_mode;
        logic [31:0] v;
        chk("R6 small idx3", 64'(fetch_addr), 64'(BASE + 48'h60));
        wr(12'h100, 7);
        rd(12'h100, v); chk("R3 large code", 64'(v), 64'h7);
        chk("R6 large idx3", 64'(fetch_addr), 64'(BASE + 48'h180));
        wr(12'h100, 5);
        rd(12'h100, v); chk("R3 bad code ignored", 64'(v), 64'h7);
        chk("R3 addr unchanged", 64'(fetch_addr), 64'(BASE + 48'h180));
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        ack(5);
        chk("R5 idx wraps", 64'(fetch_idx), 64'h0);
        ack(3);
        chk("R5 idx 3 after ring", 64'(fetch_idx), 64'h3);
        chk("R5 drained", 64'(fetch_req), 64'h0);
        done(8);
        rd(12'h00C, v); chk("R9 full done", 64'(v), 64'h0003_0008);
        wr(12'h804, 6);
        rd(12'h00C, v); chk("R8 done pos wraps", 64'(v), 64'h0001_0002);
    endtask

    task automatic t_size;
        logic [31:0] v;
        wr(12'h008, 5000);
        rd(12'h008, v); chk("R2 large clamp", 64'(v), 64'd4096);
        rd(12'h00C, v); chk("R2 done cleared", 64'(v), 64'h0);
        rd(12'h04C, v); chk("R2 alloc cleared", 64'(v), 64'h0);
        chk("R2 req cleared", 64'(fetch_req), 64'h0);
        chk("R2 idx cleared", 64'(fetch_idx), 64'h0);
        wr(12'h008, 0);
        rd(12'h008, v); chk("R2 zero -> one", 64'(v), 64'd1);
        wr(12'h808, 2);
        rd(12'h04C, v); chk("R4 size-one ring", 64'(v), 64'h0000_0001);
        wr(12'h100, 1);
        wr(12'h008, 20000);
        rd(12'h008, v); chk("R2 small clamp", 64'(v), 64'd16384);
        wr(12'h008, 300);
        rd(12'h008, v); chk("R2 in range", 64'(v), 64'd300);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; host_wen = 1'b0; host_addr = '0; host_wdata = '0;
        fetch_ack = 1'b0; done_pulse = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_post_fetch();
        t_done_release();
        t_overflow();
        t_stop();
        t_addr_mode();
        t_wrap();
        t_size();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule